// File: doc/BRIEF.md
# Inter-Access Idle Cycle Inserter

This block sits between a bus master and an external memory controller. It spaces consecutive memory accesses apart by a programmable number of idle bus cycles. The master raises a request with a read/write flag and a memory space number. The block answers with a combinational grant, and the controller signals the end of the granted access with a one-cycle completion pulse. At each completion the block records the kind and space of that access. It then holds back the next grant until the idle gap required by that pair of accesses has elapsed.

Three 2-bit fields in an 8-bit configuration register set the gap for three transitions: a read followed by a write to the same space, a read followed by a read to another space, and a read followed by a read to the same space. Each field decodes to a cycle count through its own non-linear table. Every other transition needs no gap. The field values are captured when an access completes, so the gap that follows always uses the settings that held at that moment.

Top module: `idle_gap_inserter`

## Requirements
- R1: After reset, cfg_rdata_o reads 0x3F (every field holds code 11), and the first request is granted in the cycle it is raised, because there is no access history yet.
- R2: Configuration register layout: bits [1:0] set the read-then-read same-space code, bits [3:2] the read-then-read other-space code, and bits [5:4] the read-then-write same-space code. Bits [7:6] always read 0, and writes to them are ignored. A write with cfg_we_i high is visible on cfg_rdata_o from the next cycle.
- R3: A read (rd_i=1) followed by a read to the same space waits 0, 1, 2 or 4 idle cycles for codes 00, 01, 10 and 11.
- R4: A read followed by a read to a different space waits 1, 2, 3 or 5 idle cycles for codes 00, 01, 10 and 11.
- R5: A read followed by a write (rd_i=0) to the same space waits 2, 3 or 5 idle cycles for codes 01, 10 and 11.
- R6: The forbidden code 00 in the read-then-write field acts as 5 idle cycles.
- R7: A write followed by any access, and a read followed by a write to another space, wait no idle cycles.
- R8: If done_i is high in cycle D for an access that is in flight, and the next access needs N idle cycles, gnt_o stays low in cycles D+1 to D+N. After that, gnt_o is high in the first cycle in which req_i is high and no access is in flight. gnt_o is low whenever req_i is low.
- R9: Only one access is in flight at a time. After a grant, gnt_o stays low until done_i has been seen, and the earliest next grant comes two cycles after the previous one. A done_i pulse when no access is in flight is ignored and does not restart the gap.
- R10: The gap after a completion uses the configuration that held in the completion cycle. A register write during the gap does not change the length of that gap.
- R11: Idle cycles that pass while req_i is low count toward the gap. A request raised after the gap has fully elapsed is granted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Master requests an access |
| rd_i | input | 1 | Kind of the requested access: 1 read, 0 write |
| space_i | input | SPACE_W | Memory space number of the requested access |
| gnt_o | output | 1 | Access may start in this cycle |
| done_i | input | 1 | In-flight access completes in this cycle |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration register contents |

## Verification
A corrupted history record is a stored kind, space or configuration snapshot that no longer matches the last completed access. It shows up as a grant that comes too early or too late on the very next request. Every cycle's gnt_o is therefore compared with a reference model, and each transition kind gets an explicit gap measurement under every code. An elapsed counter that restarts on a stray completion pulse, or that loses the cycles spent with no request pending, moves the grant by exactly the number of cycles it lost or gained. The stray-pulse and late-request cases are built to make that shift show up at once. Register-layout faults appear on cfg_rdata_o one cycle after the write.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;

  localparam int CFG_W    = 8;
  localparam int MAX_IDLE = 5;
  localparam int GAP_W    = $clog2(MAX_IDLE + 1);

  typedef struct packed {
    logic [1:0] rw_same;
    logic [1:0] rr_diff;
    logic [1:0] rr_same;
  } gap_cfg_t;

  localparam int FIELD_BITS = $bits(gap_cfg_t);
  localparam gap_cfg_t CFG_RESET = '1;

  typedef enum logic [1:0] {
    XFER_NONE,
    XFER_RR_SAME,
    XFER_RR_DIFF,
    XFER_RW_SAME
  } xfer_kind_t;

  function automatic logic [GAP_W-1:0] rr_same_idle(input logic [1:0] code);
    case (code)
      2'b00:   return GAP_W'(0);
      2'b01:   return GAP_W'(1);
      2'b10:   return GAP_W'(2);
      default: return GAP_W'(4);
    endcase
  endfunction

  function automatic logic [GAP_W-1:0] rr_diff_idle(input logic [1:0] code);
    case (code)
      2'b00:   return GAP_W'(1);
      2'b01:   return GAP_W'(2);
      2'b10:   return GAP_W'(3);
      default: return GAP_W'(5);
    endcase
  endfunction

  // forbidden 00 mapped to the longest gap
  function automatic logic [GAP_W-1:0] rw_same_idle(input logic [1:0] code);
    case (code)
      2'b01:   return GAP_W'(2);
      2'b10:   return GAP_W'(3);
      default: return GAP_W'(5);
    endcase
  endfunction

endpackage

// File: rtl/igi_cfg_reg.sv
module igi_cfg_reg
  import idle_gap_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [CFG_W-1:0]    wdata_i,
  output gap_cfg_t            cfg_o,
  output logic [CFG_W-1:0]    rdata_o
);

  gap_cfg_t cfg_q;
  logic     unused_rsvd;

  assign unused_rsvd = ^wdata_i[CFG_W-1:FIELD_BITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RESET;
    else if (we_i) cfg_q <= gap_cfg_t'(wdata_i[FIELD_BITS-1:0]);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {{(CFG_W-FIELD_BITS){1'b0}}, cfg_q};

  // R2
  cfg_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o == {{(CFG_W-FIELD_BITS){1'b0}}, $past(wdata_i[FIELD_BITS-1:0])});

endmodule

// File: rtl/igi_history.sv
module igi_history
  import idle_gap_pkg::*;
#(
  parameter int SPACE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               done_i,
  input  logic               rd_i,
  input  logic [SPACE_W-1:0] space_i,
  input  gap_cfg_t           cfg_i,
  output logic               busy_o,
  output logic               valid_o,
  output logic               last_rd_o,
  output logic [SPACE_W-1:0] last_space_o,
  output gap_cfg_t           snap_o,
  output logic [GAP_W-1:0]   elapsed_o
);

  logic               busy_q, valid_q, last_rd_q, pend_rd_q;
  logic [SPACE_W-1:0] last_space_q, pend_space_q;
  gap_cfg_t           snap_q;
  logic [GAP_W-1:0]   elapsed_q;
  logic               finish;

  assign finish = busy_q & done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      valid_q      <= 1'b0;
      last_rd_q    <= 1'b0;
      last_space_q <= '0;
      pend_rd_q    <= 1'b0;
      pend_space_q <= '0;
      snap_q       <= CFG_RESET;
      elapsed_q    <= '0;
    end else if (finish) begin
      busy_q       <= 1'b0;
      valid_q      <= 1'b1;
      last_rd_q    <= pend_rd_q;
      last_space_q <= pend_space_q;
      snap_q       <= cfg_i;
      elapsed_q    <= '0;
    end else if (start_i) begin
      busy_q       <= 1'b1;
      pend_rd_q    <= rd_i;
      pend_space_q <= space_i;
    end else if (!busy_q && elapsed_q != '1) begin
      elapsed_q    <= elapsed_q + GAP_W'(1);
    end
  end

  assign busy_o       = busy_q;
  assign valid_o      = valid_q;
  assign last_rd_o    = last_rd_q;
  assign last_space_o = last_space_q;
  assign snap_o       = snap_q;
  assign elapsed_o    = elapsed_q;

  // R8
  gap_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && done_i) |=> (elapsed_o == '0 && valid_o && !busy_o));

  // R10
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_i) |=> $stable(snap_o));

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_i) |=> busy_o);

endmodule

// File: rtl/igi_gap_sel.sv
module igi_gap_sel
  import idle_gap_pkg::*;
#(
  parameter int SPACE_W = 3
) (
  input  logic               valid_i,
  input  logic               last_rd_i,
  input  logic [SPACE_W-1:0] last_space_i,
  input  logic               rd_i,
  input  logic [SPACE_W-1:0] space_i,
  input  gap_cfg_t           snap_i,
  output xfer_kind_t         kind_o,
  output logic [GAP_W-1:0]   need_o
);

  always_comb begin
    kind_o = XFER_NONE;
    if (valid_i && last_rd_i) begin
      if (last_space_i == space_i) kind_o = rd_i ? XFER_RR_SAME : XFER_RW_SAME;
      else if (rd_i)               kind_o = XFER_RR_DIFF;
    end
  end

  always_comb begin
    case (kind_o)
      XFER_RR_SAME: need_o = rr_same_idle(snap_i.rr_same);
      XFER_RR_DIFF: need_o = rr_diff_idle(snap_i.rr_diff);
      XFER_RW_SAME: need_o = rw_same_idle(snap_i.rw_same);
      default:      need_o = '0;
    endcase
  end

endmodule

// File: rtl/idle_gap_inserter.sv
module idle_gap_inserter
  import idle_gap_pkg::*;
#(
  parameter int SPACE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               rd_i,
  input  logic [SPACE_W-1:0] space_i,
  output logic               gnt_o,
  input  logic               done_i,
  input  logic               cfg_we_i,
  input  logic [7:0]         cfg_wdata_i,
  output logic [7:0]         cfg_rdata_o
);

  gap_cfg_t           cfg, snap;
  logic               busy, valid, last_rd;
  logic [SPACE_W-1:0] last_space;
  logic [GAP_W-1:0]   elapsed, need;
  xfer_kind_t         kind;

  igi_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  igi_history #(.SPACE_W(SPACE_W)) u_hist (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (gnt_o),
    .done_i       (done_i),
    .rd_i         (rd_i),
    .space_i      (space_i),
    .cfg_i        (cfg),
    .busy_o       (busy),
    .valid_o      (valid),
    .last_rd_o    (last_rd),
    .last_space_o (last_space),
    .snap_o       (snap),
    .elapsed_o    (elapsed)
  );

  igi_gap_sel #(.SPACE_W(SPACE_W)) u_sel (
    .valid_i      (valid),
    .last_rd_i    (last_rd),
    .last_space_i (last_space),
    .rd_i         (rd_i),
    .space_i      (space_i),
    .snap_i       (snap),
    .kind_o       (kind),
    .need_o       (need)
  );

  assign gnt_o = req_i & ~busy & (elapsed >= need);

  // R9
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |=> !gnt_o);

  // R7
  no_wr_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && !last_rd && req_i && !busy) |-> gnt_o);

  // R6
  rw_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == XFER_RW_SAME) |-> (need >= GAP_W'(2)));

  // R3
  rr_same_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == XFER_RR_SAME && req_i && !busy && elapsed == '0 && snap.rr_same != 2'b00) |-> !gnt_o);

endmodule

// File: tb/idle_gap_inserter_bench.sv
`timescale 1ns/1ps
module idle_gap_inserter_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req, rd_s, done, cfg_we, gnt;
  logic [2:0] space;
  logic [7:0] cfg_wd, cfg_rd;

  always #2.5 clk = ~clk;

  idle_gap_inserter #(.SPACE_W(3)) u_idle_gap_inserter (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rd_i(rd_s), .space_i(space),
    .gnt_o(gnt), .done_i(done), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
    .cfg_rdata_o(cfg_rd)
  );

  int checks = 0, errors = 0;

  // reference model state
  bit       m_busy, m_have, m_lrd, m_prd;
  bit [2:0] m_lsp, m_psp;
  bit [5:0] m_cfg = 6'h3F, m_snap = 6'h3F;
  int       m_cnt;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rrs_tbl(input bit [1:0] c);  // R3
    int t[4] = '{0, 1, 2, 4}; return t[c];
  endfunction
  function automatic int rrd_tbl(input bit [1:0] c);  // R4
    int t[4] = '{1, 2, 3, 5}; return t[c];
  endfunction
  function automatic int rws_tbl(input bit [1:0] c);  // R5, R6
    int t[4] = '{5, 2, 3, 5}; return t[c];
  endfunction

  function automatic int need_m(input bit nrd, input bit [2:0] nsp);
    if (!m_have || !m_lrd) return 0;            // R7
    if (m_lsp == nsp) return nrd ? rrs_tbl(m_snap[1:0]) : rws_tbl(m_snap[5:4]);
    return nrd ? rrd_tbl(m_snap[3:2]) : 0;
  endfunction

  task automatic step(input bit r, input bit rd, input bit [2:0] sp, input bit dn,
                      input bit we, input bit [7:0] wd, output bit g);
    bit e;
    @(negedge clk);
    req = r; rd_s = rd; space = sp; done = dn; cfg_we = we; cfg_wd = wd;
    #1;
    e = r && !m_busy && (m_cnt >= need_m(rd, sp));
    g = gnt;
    chk(g == e, m_busy ? "R9" : "R8", g, e);
    if (m_busy && dn) begin
      m_busy = 0; m_have = 1; m_lrd = m_prd; m_lsp = m_psp; m_snap = m_cfg; m_cnt = 0;
    end else if (e) begin
      m_busy = 1; m_prd = rd; m_psp = sp;
    end else if (!m_busy && m_cnt < 7) m_cnt++;
    if (we) m_cfg = wd[5:0];
  endtask

  task automatic run_gap(input bit prd, input bit [2:0] psp, input bit nrd, input bit [2:0] nsp,
                         input int wait_n, input bit stray, input bit we, input bit [7:0] wd,
                         output int gap);
    bit g = 0;
    bit first = 1;
    int k = 0;
    while (!g && k < 20) begin step(1, prd, psp, 0, 0, 0, g); k++; end
    step(0, prd, psp, 1, 0, 0, g);
    for (int i = 0; i < wait_n; i++) step(0, 0, 0, stray && i == 0, we && i == 0, wd, g);
    gap = 0; g = 0;
    while (!g && gap < 20) begin
      step(1, nrd, nsp, 0, we && wait_n == 0 && first, wd, g);
      first = 0;
      if (!g) gap++;
    end
    step(0, nrd, nsp, 1, 0, 0, g);
  endtask

  task automatic wr_cfg(input bit [7:0] wd);
    bit g;
    step(0, 0, 0, 0, 1, wd, g);
    step(0, 0, 0, 0, 0, 0, g);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R8 watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit g, hold, hr, we;
    bit [2:0] hs;
    bit [7:0] wd;
    int gap, seed;
    rst_n = 0; req = 0; rd_s = 0; space = 0; done = 0; cfg_we = 0; cfg_wd = 0;
    seed = $urandom(32'h1d5);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(cfg_rd == 8'h3F, "R1", cfg_rd, 8'h3F);
    step(1, 1, 0, 0, 0, 0, g);
    chk(g == 1, "R1", g, 1);
    step(0, 1, 0, 1, 0, 0, g);

    for (int c = 0; c < 4; c++) begin
      wr_cfg({2'b11, 2'(c), 2'(c), 2'(c)});
      chk(cfg_rd == {2'b00, 2'(c), 2'(c), 2'(c)}, "R2", cfg_rd, {2'b00, 2'(c), 2'(c), 2'(c)});
      run_gap(1, 1, 1, 1, 0, 0, 0, 0, gap);
      chk(gap == rrs_tbl(2'(c)), "R3", gap, rrs_tbl(2'(c)));
      run_gap(1, 2, 1, 5, 0, 0, 0, 0, gap);
      chk(gap == rrd_tbl(2'(c)), "R4", gap, rrd_tbl(2'(c)));
      run_gap(1, 3, 0, 3, 0, 0, 0, 0, gap);
      chk(gap == rws_tbl(2'(c)), (c == 0) ? "R6" : "R5", gap, rws_tbl(2'(c)));
      run_gap(0, 4, 1, 4, 0, 0, 0, 0, gap);
      chk(gap == 0, "R7", gap, 0);
      run_gap(1, 0, 0, 1, 0, 0, 0, 0, gap);
      chk(gap == 0, "R7", gap, 0);
    end

    // mixed field codes: each field must be decoded from its own bits
    wr_cfg(8'h1B); // rw=01 rr_diff=10 rr_same=11
    run_gap(1, 6, 0, 6, 0, 0, 0, 0, gap);
    chk(gap == 2, "R2", gap, 2);
    run_gap(1, 6, 1, 7, 0, 0, 0, 0, gap);
    chk(gap == 3, "R2", gap, 3);

    // config write during the gap keeps the captured length
    wr_cfg(8'h3F);
    run_gap(1, 1, 1, 1, 0, 0, 1, 8'h00, gap);
    chk(gap == 4, "R10", gap, 4);
    step(0, 0, 0, 0, 0, 0, g);
    chk(cfg_rd == 8'h00, "R10", cfg_rd, 0);
    wr_cfg(8'h3F);

    run_gap(1, 2, 1, 2, 6, 0, 0, 0, gap);
    chk(gap == 0, "R11", gap, 0);
    run_gap(1, 2, 1, 2, 2, 1, 0, 0, gap);
    chk(gap == 2, "R9", gap, 2);

    hold = 0; hr = 0; hs = 0;
    for (int n = 0; n < 4000; n++) begin
      we = ($urandom % 16) == 0;
      wd = 8'($urandom);
      if (m_busy) step(0, hr, hs, ($urandom % 3) == 0, we, wd, g);
      else begin
        if (!hold && ($urandom % 2)) begin
          hold = 1; hr = 1'($urandom); hs = 3'($urandom % 3);
        end
        step(hold, hr, hs, ($urandom % 8) == 0, we, wd, g);
        if (g) hold = 0;
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule